// File: doc/BRIEF.md
# Dual-Format PHY Management Serial Controller

This block is a register-driven management master for Clause 22 PHY access. Software writes a command into a control register. The block then sends one serial management frame to an external PHY on a divided management clock. A completed read leaves the PHY's 16-bit answer in a data register.

Two incompatible command encodings are supported, and a bit of a feature register picks one at run time:

- **Packed format.** A single fire bit starts the command. The opcode, PHY address, register address and write data all travel in the control word. Read results land in the low half of the data register.
- **Legacy format.** Separate write and read strobe bits start the command. Write data is taken from the data register. Read results land in its high half.

The command bit stays set and `busy` stays high while a frame is in flight. Both clear together when the last bit has been sent.

Top module: `mgmt_ser_ctl`

## Requirements
- R1: After reset, the control (address 0), data (address 1) and feature (address 2) registers read zero, and address 3 reads zero. `busy`, `mdc` and `mdio_oe` are low.
- R2: A write to the feature register stores all 32 bits as written. Its bit 31 selects the packed format when 1 and the legacy format when 0.
- R3: Frame layout: 32 ones, then start 01, then opcode (01 write, 10 read), then 5-bit PHY address, then 5-bit register address, then turnaround 10, then 16 data bits, all MSB first. Each bit is set up while `mdc` is low and holds across the `mdc` rising edge. Each `mdc` half period lasts `cfg_half` clock cycles, with 0 treated as 1. While idle, `mdc` and `mdio_oe` stay low.
- R4: On a read frame, `mdio_oe` is low from the first turnaround bit to the end of the frame. The PHY's data bits are sampled on the `mdc` rising edges.
- R5: Packed-format control layout: write data in bits 31:16, fire in bit 15, start-code flag in bit 12, opcode in bits 11:10, PHY address in bits 9:5, register address in bits 4:0. Fire, flag and opcode 01 together send a write frame carrying bits 31:16.
- R6: A packed-format read (opcode 10) replaces the data register with the 16-bit result in bits 15:0 and zero in bits 31:16.
- R7: A packed-format command with fire set but the start-code flag clear sends no frame. The control register keeps the written value, fire included.
- R8: A packed-format control write with fire clear sends no frame and is stored as written.
- R9: A packed-format command with opcode 00 or 11 sends no frame. It is stored with fire cleared.
- R10: Legacy layout: write strobe in bit 27, read strobe in bit 26, register address in bits 25:21, PHY address in bits 20:16. A write takes its data from data-register bits 15:0. When both strobes are set, the write runs, and only the strobe of the command that ran is cleared.
- R11: A legacy read replaces the data register with the result in bits 31:16 and zero in bits 15:0. A legacy control write with neither strobe set sends no frame and is stored as written.
- R12: From the write that starts a command until the frame ends, `busy` is high and the command bit reads as set. Both clear in the same cycle. Control writes made while `busy` is high are ignored. A data-register write in the same cycle as a read's completion is overwritten by the read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | DIV_W | Management clock half period in clock cycles (0 acts as 1) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by `reg_addr` |
| busy | output | 1 | A frame is in flight |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Serial data returned by the PHY |

## Verification
Frame completion can fall in the same cycle as a software register write, and the block must resolve the conflict. The bench provokes this by writing on every cycle in which `busy` reads high, so the last write lands exactly on the completion edge. With a data-register write in flight, the read result must win. With a new fire command in flight, the command must be dropped: no `mdc` edges follow, `busy` stays low, and the control register shows the finished command with its fire bit cleared.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_DATA = 2'd1,
      A_FEAT = 2'd2
   } reg_addr_e;

   localparam int FEAT_PACKED = 31;
   // packed-format control fields
   localparam int P_FIRE   = 15;
   localparam int P_ST     = 12;
   localparam int P_OP_LO  = 10;
   localparam int P_PHY_LO = 5;
   localparam int P_REG_LO = 0;
   localparam int P_WD_LO  = 16;
   // legacy-format control fields
   localparam int L_WR     = 27;
   localparam int L_RD     = 26;
   localparam int L_REG_LO = 21;
   localparam int L_PHY_LO = 16;

   localparam logic [1:0] OP_WR = 2'b01;
   localparam logic [1:0] OP_RD = 2'b10;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;
   logic             tick;

   assign lim  = (half == '0) ? DIV_W'(1) : half;
   assign tick = run && (cnt == lim - DIV_W'(1));
   assign rise = tick && !mdc;
   assign fall = tick && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end
endmodule

// File: rtl/mgmt_frame_eng.sv
module mgmt_frame_eng #(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        is_rd,
   input  logic [4:0]  phy,
   input  logic [4:0]  regn,
   input  logic [15:0] wdata,
   input  logic        rise,
   input  logic        fall,
   input  logic        mdio_i,
   output logic        run,
   output logic        done,
   output logic [15:0] rdata,
   output logic        mdio_o,
   output logic        mdio_oe
);
   localparam int FLEN = PRE_LEN + 32;
   localparam int IW   = $clog2(FLEN);
   localparam logic [IW-1:0] TA_IDX   = IW'(PRE_LEN + 14);
   localparam logic [IW-1:0] DAT_IDX  = IW'(PRE_LEN + 16);
   localparam logic [IW-1:0] LAST_IDX = IW'(FLEN - 1);

   logic [FLEN-1:0] sh;
   logic [IW-1:0]   idx;
   logic            rd_q;
   logic [15:0]     rsh;

   assign done    = run && fall && (idx == LAST_IDX);
   assign rdata   = rsh;
   assign mdio_o  = sh[FLEN-1];
   assign mdio_oe = run && !(rd_q && (idx >= TA_IDX));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         idx  <= '0;
         run  <= 1'b0;
         rd_q <= 1'b0;
         rsh  <= '0;
      end else if (start) begin
         sh   <= {{PRE_LEN{1'b1}}, 2'b01, (is_rd ? mgmt_pkg::OP_RD : mgmt_pkg::OP_WR),
                  phy, regn, (is_rd ? 2'b11 : 2'b10), (is_rd ? 16'hFFFF : wdata)};
         idx  <= '0;
         run  <= 1'b1;
         rd_q <= is_rd;
         rsh  <= '0;
      end else if (run) begin
         if (rise && (idx >= DAT_IDX)) rsh <= {rsh[14:0], mdio_i};
         if (fall) begin
            sh  <= {sh[FLEN-2:0], 1'b1};
            idx <= idx + IW'(1);
            if (idx == LAST_IDX) run <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mgmt_ser_ctl.sv
module mgmt_ser_ctl
   import mgmt_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int PRE_LEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_half,
   input  logic             reg_we,
   input  logic [1:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             busy,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("mgmt_ser_ctl: DIV_W out of range");
      end
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("mgmt_ser_ctl: PRE_LEN out of range");
      end
   endgenerate

   logic [31:0] ctrl_q, data_q, feat_q;
   logic        act_new_q, act_rd_q;
   logic        ctl_acc, go, go_rd, done, rise, fall;
   logic [4:0]  go_phy, go_reg;
   logic [15:0] go_wd, rd_word;
   logic [31:0] ctrl_nx;
   logic        packed_fmt;

   assign packed_fmt = feat_q[FEAT_PACKED];
   assign ctl_acc    = reg_we && (reg_addr == A_CTRL) && !busy;

   always_comb begin
      go      = 1'b0;
      go_rd   = 1'b0;
      ctrl_nx = reg_wdata;
      go_phy  = packed_fmt ? reg_wdata[P_PHY_LO +: 5] : reg_wdata[L_PHY_LO +: 5];
      go_reg  = packed_fmt ? reg_wdata[P_REG_LO +: 5] : reg_wdata[L_REG_LO +: 5];
      go_wd   = packed_fmt ? reg_wdata[P_WD_LO +: 16] : data_q[15:0];
      if (ctl_acc) begin
         if (packed_fmt) begin
            if (reg_wdata[P_ST] && reg_wdata[P_FIRE]) begin
               case (reg_wdata[P_OP_LO +: 2])
                  OP_WR:   go = 1'b1;
                  OP_RD:   begin go = 1'b1; go_rd = 1'b1; end
                  default: ctrl_nx[P_FIRE] = 1'b0;
               endcase
            end
         end else if (reg_wdata[L_WR]) begin
            go = 1'b1;
         end else if (reg_wdata[L_RD]) begin
            go    = 1'b1;
            go_rd = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         data_q    <= '0;
         feat_q    <= '0;
         act_new_q <= 1'b0;
         act_rd_q  <= 1'b0;
      end else begin
         if (ctl_acc) ctrl_q <= ctrl_nx;
         if (reg_we && reg_addr == A_FEAT) feat_q <= reg_wdata;
         if (reg_we && reg_addr == A_DATA) data_q <= reg_wdata;
         if (go) begin
            act_new_q <= packed_fmt;
            act_rd_q  <= go_rd;
         end
         if (done) begin
            if (act_new_q)     ctrl_q[P_FIRE] <= 1'b0;
            else if (act_rd_q) ctrl_q[L_RD]   <= 1'b0;
            else               ctrl_q[L_WR]   <= 1'b0;
            if (act_rd_q) data_q <= act_new_q ? {16'h0000, rd_word} : {rd_word, 16'h0000};
         end
      end
   end

   always_comb begin
      case (reg_addr)
         A_CTRL:  reg_rdata = ctrl_q;
         A_DATA:  reg_rdata = data_q;
         A_FEAT:  reg_rdata = feat_q;
         default: reg_rdata = '0;
      endcase
   end

   mgmt_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
      .clk(clk), .rst_n(rst_n), .run(busy), .half(cfg_half),
      .mdc(mdc), .rise(rise), .fall(fall)
   );

   mgmt_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(go), .is_rd(go_rd),
      .phy(go_phy), .regn(go_reg), .wdata(go_wd),
      .rise(rise), .fall(fall), .mdio_i(mdio_i),
      .run(busy), .done(done), .rdata(rd_word),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );
endmodule

// File: rtl/mgmt_ser_ctl_chk.sv
module mgmt_ser_ctl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic        reg_we,
   input logic [1:0]  reg_addr,
   input logic [31:0] ctrl_q,
   input logic        act_new_q,
   input logic        act_rd_q
);
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   p_setup_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $rose(mdc)) |-> $stable(mdio_o));

   p_start_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_we && reg_addr == 2'd0));

   p_ctrl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ctrl_q));

   p_fire_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && act_new_q) |-> !ctrl_q[15]);

   p_strobe_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !act_new_q) |-> (act_rd_q ? !ctrl_q[26] : !ctrl_q[27]));
endmodule

bind mgmt_ser_ctl mgmt_ser_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
   .mdio_oe(mdio_oe), .reg_we(reg_we), .reg_addr(reg_addr),
   .ctrl_q(ctrl_q), .act_new_q(act_new_q), .act_rd_q(act_rd_q)
);

// File: tb/sim_mgmt_ser_ctl.sv
`timescale 1ns/1ps
module sim_mgmt_ser_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_half = 8'd2;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        busy, mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int          nchk = 0, nbad = 0;
   int          bitcnt = 0, nrise = 0;
   logic [63:0] frame_cap = '0, oe_cap = '0;
   logic [15:0] phy_rdval = '0;
   realtime     t_r0, t_r1;

   always #2.5 clk = ~clk;

   mgmt_ser_ctl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY side: capture driven bits on rising MDC, return read data on falling MDC
   always @(posedge mdc) begin
      if (bitcnt == 0) t_r0 = $realtime;
      if (bitcnt == 1) t_r1 = $realtime;
      frame_cap = {frame_cap[62:0], mdio_o};
      oe_cap    = {oe_cap[62:0], mdio_oe};
      bitcnt    = bitcnt + 1;
      nrise     = nrise + 1;
   end
   always @(negedge mdc) begin
      if (bitcnt >= 48 && bitcnt <= 63) mdio_i = phy_rdval[63 - bitcnt];
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic arm();
      bitcnt = 0; frame_cap = '0; oe_cap = '0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
   endtask

   function automatic logic [63:0] exp_frame(input bit isrd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (isrd ? 2'b10 : 2'b01), p, r,
              (isrd ? 2'b00 : 2'b10), (isrd ? 16'h0000 : d)};
   endfunction

   function automatic logic [31:0] pk(input logic [15:0] d, input bit fire, input bit st,
                                      input logic [1:0] op, input logic [4:0] p, input logic [4:0] r);
      return {d, fire, 2'b00, st, op, p, r};
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd(2'd0, v); chk("R1 ctrl", v, 0);
      rd(2'd1, v); chk("R1 data", v, 0);
      rd(2'd2, v); chk("R1 feat", v, 0);
      rd(2'd3, v); chk("R1 addr3", v, 0);
      chk("R1 pins", {busy, mdc, mdio_oe}, 0);
   endtask

   task automatic t_feature();
      logic [31:0] v;
      wr(2'd2, 32'h8000_1234);
      rd(2'd2, v); chk("R2 feat store", v, 32'h8000_1234);
   endtask

   task automatic no_frame(input string tag, input logic [31:0] cmd, input logic [31:0] expc);
      logic [31:0] v;
      int n0;
      n0 = nrise;
      wr(2'd0, cmd);
      repeat (20) @(negedge clk);
      chk({tag, " no frame"}, {busy, 32'(nrise - n0)}, 0);
      rd(2'd0, v); chk({tag, " ctrl"}, v, expc);
   endtask

   task automatic t_new_write(input logic [7:0] half, input realtime per);
      logic [31:0] v, cmd;
      cfg_half = half;
      cmd = pk(16'hBEEF, 1, 1, 2'b01, 5'h0A, 5'h13);
      arm();
      wr(2'd0, cmd);
      rd(2'd0, v);
      chk("R12 busy+fire set", {busy, v[15]}, 2'b11);
      wait_idle();
      chk("R5 R3 write frame", frame_cap, exp_frame(0, 5'h0A, 5'h13, 16'hBEEF));
      chk("R3 write oe", oe_cap, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R3 mdc period", 64'(longint'((t_r1 - t_r0) * 10.0)), 64'(longint'(per * 10.0)));
      rd(2'd0, v); chk("R12 fire cleared", v, cmd & ~32'h8000);
      cfg_half = 8'd2;
   endtask

   task automatic t_new_read();
      logic [31:0] v;
      phy_rdval = 16'hC3A5;
      wr(2'd1, 32'hFFFF_FFFF);
      arm();
      wr(2'd0, pk(16'h5555, 1, 1, 2'b10, 5'h11, 5'h02));
      wait_idle();
      chk("R3 read frame head", frame_cap[63:18], exp_frame(1, 5'h11, 5'h02, 0) >> 18);
      chk("R4 read oe", oe_cap, {{46{1'b1}}, 18'h0});
      rd(2'd1, v); chk("R6 read data", v, 32'h0000_C3A5);
   endtask

   task automatic t_new_ignored();
      logic [31:0] c;
      c = pk(16'h1111, 1, 0, 2'b01, 5'h01, 5'h01);
      no_frame("R7 no start code", c, c);
      c = pk(16'h2222, 0, 1, 2'b10, 5'h02, 5'h03);
      no_frame("R8 fire clear", c, c);
      c = pk(16'h3333, 1, 1, 2'b00, 5'h04, 5'h05);
      no_frame("R9 op 00", c, c & ~32'h8000);
      c = pk(16'h4444, 1, 1, 2'b11, 5'h06, 5'h07);
      no_frame("R9 op 11", c, c & ~32'h8000);
   endtask

   task automatic t_legacy();
      logic [31:0] v, cmd;
      wr(2'd2, 32'h0000_0000);
      wr(2'd1, 32'hABCD_7E81);
      cmd = (32'h1 << 27) | (32'h1 << 26) | (32'h0C << 21) | (32'h15 << 16);
      arm();
      wr(2'd0, cmd);
      wait_idle();
      chk("R10 legacy write frame", frame_cap, exp_frame(0, 5'h15, 5'h0C, 16'h7E81));
      rd(2'd0, v); chk("R10 only write strobe cleared", v, cmd & ~(32'h1 << 27));
      phy_rdval = 16'h9C3F;
      wr(2'd1, 32'hFFFF_FFFF);
      arm();
      wr(2'd0, (32'h1 << 26) | (32'h03 << 21) | (32'h1E << 16));
      wait_idle();
      chk("R11 legacy read frame head", frame_cap[63:18], exp_frame(1, 5'h1E, 5'h03, 0) >> 18);
      rd(2'd1, v); chk("R11 legacy read data", v, 32'h9C3F_0000);
      cmd = (32'h07 << 21) | (32'h09 << 16) | 32'h0000_00FF;
      no_frame("R11 no strobe", cmd, cmd);
   endtask

   task automatic t_collide();
      logic [31:0] v, cmd;
      int n0;
      // legacy read, data register hammered until completion
      phy_rdval = 16'h5AF0;
      arm();
      wr(2'd0, (32'h1 << 26) | (32'h01 << 21) | (32'h02 << 16));
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (!busy) break;
         reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1234_5678;
      end
      reg_we = 1'b0;
      rd(2'd1, v); chk("R12 read beats data write", v, 32'h5AF0_0000);
      // packed write, control register hammered until completion
      wr(2'd2, 32'h8000_0000);
      cmd = pk(16'h0F0F, 1, 1, 2'b01, 5'h03, 5'h04);
      arm();
      wr(2'd0, cmd);
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (!busy) break;
         reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = pk(16'hFFFF, 1, 1, 2'b10, 5'h1F, 5'h1F);
      end
      reg_we = 1'b0;
      n0 = nrise;
      repeat (20) @(negedge clk);
      chk("R12 busy write dropped", {busy, 32'(nrise - n0)}, 0);
      rd(2'd0, v); chk("R12 ctrl after collide", v, cmd & ~32'h8000);
      chk("R12 frame unaltered", frame_cap, exp_frame(0, 5'h03, 5'h04, 16'h0F0F));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_feature();
      t_new_write(8'd2, 20.0);
      t_new_write(8'd3, 30.0);
      t_new_write(8'd0, 10.0);
      t_new_read();
      t_new_ignored();
      t_legacy();
      t_collide();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nbad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
   end
endmodule